// File: doc/BRIEF.md
# Load-Store Address Generation Unit

This unit computes the memory address for one load or store from a 32-bit base pointer and an element-count offset. It also computes the value that may be written back to the base register. The offset is scaled by the access size, so one offset unit always means one element. The offset comes either from a register operand or from a 5-bit unsigned immediate. A 3-bit mode code picks one of seven addressing forms. Those forms differ in two ways: whether the modified pointer or the original pointer addresses memory, and whether the modified pointer is written back.

From the effective address the unit derives the enables for the eight byte lanes of a 64-bit memory beat. It flags accesses that are not naturally aligned, and it rejects a doubleword store, because store data is at most 32 bits wide. Either error removes both the lane enables and the write-back.

A second, independent path receives a 64-bit beat returned by memory and returns the addressed element. It takes the element size and the low address bits as inputs. Byte and halfword elements are sign-extended to 32 bits. Word elements are returned as they are, and a doubleword returns the whole beat as a register pair. Both paths are registered, and a result appears one clock after its request.

Top module: `lsu_agen`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero.
- R2: The size code is 0 for byte, 1 for halfword, 2 for word and 3 for doubleword. The offset is shifted left by the size code, modulo 2^32. The offset is the zero-extended `req_imm_off` when `req_use_imm` is 1, and `req_reg_off` otherwise.
- R3: The mode code selects the effective address `ea`:
  - 0 and 7 use the base.
  - 1 uses base+scaled offset and 2 uses base−scaled offset, both as a temporary offset.
  - 3 uses base+scaled offset and 4 uses base−scaled offset, both written back (pre-modify).
  - 5 and 6 use the unmodified base, and then write back base+scaled offset (mode 5) or base−scaled offset (mode 6) (post-modify).
- R4: `wb_en` can be 1 only for modes 3 to 6, and then `wb_value` is the modified base. For modes 0, 1, 2 and 7, `wb_en` is 0 and `wb_value` equals the base.
- R5: `byte_en` bit i enables byte lane i of the beat, little-endian. For an error-free access, the enabled lanes run upward from lane `ea[2:0]` over 1, 2, 4 or 8 lanes according to size.
- R6: `misalign_err` is 1 when `ea` is not a multiple of the element size. It forces `wb_en` and `byte_en` to zero.
- R7: A store (`req_is_store`=1) of size 3 sets `size_err` and forces `wb_en` and `byte_en` to zero. Loads of size 3 are accepted.
- R8: For a byte or halfword load, `ld_result[31:0]` holds the element taken from the lane chosen by `ld_addr_lo`, sign-extended. Address bits below the element size are ignored, and `ld_result[63:32]` is zero.
- R9: For a word load, `ld_result[31:0]` is the word at `ld_addr_lo[2]` and the upper half is zero. For a doubleword load, `ld_result` is the whole beat.
- R10: The address results and `rsp_valid` follow `req_valid` by one clock, and `ld_result` and `ld_valid` follow `ld_req` by one clock. An output holds its value while its request input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address request present this cycle |
| req_is_store | input | 1 | 1 for a store, 0 for a load |
| req_base | input | 32 | Base pointer |
| req_reg_off | input | 32 | Register offset in elements |
| req_imm_off | input | 5 | Unsigned immediate offset in elements |
| req_use_imm | input | 1 | Selects the immediate offset |
| req_mode | input | 3 | Addressing mode code |
| req_size | input | 2 | Access size code |
| ld_req | input | 1 | Load beat present this cycle |
| ld_beat | input | 64 | 64-bit memory beat |
| ld_size | input | 2 | Element size code of the load |
| ld_addr_lo | input | 3 | Low address bits of the load |
| rsp_valid | output | 1 | Address results updated |
| ea | output | 32 | Effective byte address |
| wb_value | output | 32 | New base value |
| wb_en | output | 1 | Base write-back enable |
| byte_en | output | 8 | Byte-lane enables |
| misalign_err | output | 1 | Misaligned access flag |
| size_err | output | 1 | Doubleword store rejected |
| ld_valid | output | 1 | Load result updated |
| ld_result | output | 64 | Aligned and extended load data |

## Verification
An address request and the alignment of a returned load beat can arrive in the same cycle, because the two paths share only the clock. The bench provokes this by issuing a load beat on every cycle of the address sweep. The sweep covers every mode, size, direction, base pattern and offset source. The load beat's size and lane come from a counter, so all 32 size/lane pairs are visited many times. In each cycle the bench checks both result sets against values it computes independently, so interference between the two paths would show up as a mismatch on either side.

// File: rtl/agen_pkg.sv
// Package: shared codes for the address generation unit.
// Assumes size codes 0..3 map to 1, 2, 4 and 8 byte elements.
package agen_pkg;
    typedef enum logic [2:0] {
        AM_PLAIN   = 3'd0,
        AM_OFS_ADD = 3'd1,
        AM_OFS_SUB = 3'd2,
        AM_PRE_INC = 3'd3,
        AM_PRE_DEC = 3'd4,
        AM_PST_INC = 3'd5,
        AM_PST_DEC = 3'd6,
        AM_SPARE   = 3'd7
    } amode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } asize_e;
endpackage

// File: rtl/agen_addr_calc.sv
// Module: agen_addr_calc
// Picks the offset source, scales it by the element size, and forms the
// modified pointer, the effective address and the candidate write-back.
// Assumes a purely combinational context. All arithmetic wraps modulo 2^ADDR_W.
module agen_addr_calc
    import agen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] reg_off,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic              use_imm,
    input  amode_e            mode,
    input  asize_e            size,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] wb_value,
    output logic              wants_wb
);
    localparam int PAD_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] off_sel;
    logic [ADDR_W-1:0] scaled;
    logic [ADDR_W-1:0] modified;
    logic              subtract;

    // Select the offset source and scale element count to bytes.
    always_comb begin
        off_sel = use_imm ? {{PAD_W{1'b0}}, imm_off} : reg_off;
        scaled  = off_sel << size;
    end

    // Decide the direction of modification from the mode code.
    always_comb begin
        subtract = (mode == AM_OFS_SUB) || (mode == AM_PRE_DEC) || (mode == AM_PST_DEC);
        modified = subtract ? (base - scaled) : (base + scaled);
    end

    // Route modified or original pointer to the address and write-back.
    always_comb begin
        ea       = base;
        wb_value = base;
        wants_wb = 1'b0;
        unique case (mode)
            AM_OFS_ADD, AM_OFS_SUB: ea = modified;
            AM_PRE_INC, AM_PRE_DEC: begin
                ea       = modified;
                wb_value = modified;
                wants_wb = 1'b1;
            end
            AM_PST_INC, AM_PST_DEC: begin
                wb_value = modified;
                wants_wb = 1'b1;
            end
            default: ea = base;
        endcase
    end
endmodule

// File: rtl/agen_lane_ctl.sv
// Module: agen_lane_ctl
// Checks natural alignment and the store size limit, and builds the byte-lane
// enables of one memory beat. Assumes BEAT_BYTES is a power of two no smaller
// than the largest element (8 bytes).
module agen_lane_ctl
    import agen_pkg::*;
#(
    parameter int BEAT_BYTES = 8,
    parameter int LANE_W     = $clog2(BEAT_BYTES)
) (
    input  logic [LANE_W-1:0]     ea_lo,
    input  asize_e                size,
    input  logic                  is_store,
    input  logic                  wants_wb,
    output logic [BEAT_BYTES-1:0] byte_en,
    output logic                  misalign,
    output logic                  size_bad,
    output logic                  wb_ok
);
    localparam int CW = LANE_W + 2;

    logic [CW-1:0]         elem_bytes;
    logic [CW-1:0]         lane_lo;
    logic [CW-1:0]         lane_hi;
    logic [LANE_W-1:0]     align_mask;
    logic [BEAT_BYTES-1:0] lane_hit;
    logic                  any_err;

    // Derive element span and the low-bit alignment mask from size.
    always_comb begin
        elem_bytes = CW'(1) << size;
        align_mask = LANE_W'(elem_bytes - CW'(1));
        lane_lo    = {2'b00, ea_lo};
        lane_hi    = lane_lo + elem_bytes;
    end

    // Flag alignment and store-width errors.
    always_comb begin
        misalign = (ea_lo & align_mask) != '0;
        size_bad = is_store && (size == SZ_DBL);
        any_err  = misalign || size_bad;
        wb_ok    = wants_wb && !any_err;
    end

    // One comparator pair per lane marks the lanes covered by the element.
    for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_lane
        always_comb lane_hit[i] = (CW'(i) >= lane_lo) && (CW'(i) < lane_hi);
    end

    // Suppress all lanes on any error.
    always_comb byte_en = any_err ? '0 : lane_hit;
endmodule

// File: rtl/agen_load_align.sv
// Module: agen_load_align
// Extracts the addressed element from a little-endian beat. Bytes and halves
// are sign-extended to 32 bits, a word is zero-padded, a doubleword passes whole.
// Assumes a 64-bit beat. Address bits below the element size are ignored.
module agen_load_align
    import agen_pkg::*;
#(
    parameter int BEAT_W = 64,
    parameter int LANE_W = $clog2(BEAT_W / 8)
) (
    input  logic [BEAT_W-1:0] beat,
    input  asize_e            size,
    input  logic [LANE_W-1:0] lo,
    output logic [BEAT_W-1:0] result
);
    localparam int NB = BEAT_W / 8;
    localparam int NH = BEAT_W / 16;
    localparam int NW = BEAT_W / 32;

    logic [7:0]  bytes_a [NB];
    logic [15:0] halves_a[NH];
    logic [31:0] words_a [NW];
    logic [7:0]  b_sel;
    logic [15:0] h_sel;
    logic [31:0] w_sel;

    // Slice the beat into element arrays of each width.
    for (genvar i = 0; i < NB; i++) begin : g_b
        always_comb bytes_a[i] = beat[8*i +: 8];
    end
    for (genvar i = 0; i < NH; i++) begin : g_h
        always_comb halves_a[i] = beat[16*i +: 16];
    end
    for (genvar i = 0; i < NW; i++) begin : g_w
        always_comb words_a[i] = beat[32*i +: 32];
    end

    // Pick one element of each width by the relevant address bits.
    always_comb begin
        b_sel = bytes_a[lo];
        h_sel = halves_a[lo[LANE_W-1:1]];
        w_sel = words_a[lo[LANE_W-1]];
    end

    // Extend the selected element into the destination format.
    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(BEAT_W-32){1'b0}}, {24{b_sel[7]}}, b_sel};
            SZ_HALF: result = {{(BEAT_W-32){1'b0}}, {16{h_sel[15]}}, h_sel};
            SZ_WORD: result = {{(BEAT_W-32){1'b0}}, w_sel};
            default: result = beat;
        endcase
    end
endmodule

// File: rtl/lsu_agen.sv
// Module: lsu_agen
// Top of the load-store address generation unit. It registers one address
// result per request and, independently, one aligned load result per beat.
// Assumes a 32-bit address, a 5-bit immediate and a 64-bit memory beat.
module lsu_agen
    import agen_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IMM_W      = 5,
    parameter int BEAT_BYTES = 8,
    parameter int BEAT_W     = BEAT_BYTES * 8,
    parameter int LANE_W     = $clog2(BEAT_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_is_store,
    input  logic [ADDR_W-1:0]     req_base,
    input  logic [ADDR_W-1:0]     req_reg_off,
    input  logic [IMM_W-1:0]      req_imm_off,
    input  logic                  req_use_imm,
    input  logic [2:0]            req_mode,
    input  logic [1:0]            req_size,
    input  logic                  ld_req,
    input  logic [BEAT_W-1:0]     ld_beat,
    input  logic [1:0]            ld_size,
    input  logic [LANE_W-1:0]     ld_addr_lo,
    output logic                  rsp_valid,
    output logic [ADDR_W-1:0]     ea,
    output logic [ADDR_W-1:0]     wb_value,
    output logic                  wb_en,
    output logic [BEAT_BYTES-1:0] byte_en,
    output logic                  misalign_err,
    output logic                  size_err,
    output logic                  ld_valid,
    output logic [BEAT_W-1:0]     ld_result
);
    logic [ADDR_W-1:0]     ea_c;
    logic [ADDR_W-1:0]     wbv_c;
    logic                  wants_wb_c;
    logic [BEAT_BYTES-1:0] be_c;
    logic                  mis_c;
    logic                  szb_c;
    logic                  wbok_c;
    logic [BEAT_W-1:0]     ld_c;

    agen_addr_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_calc (
        .base    (req_base),
        .reg_off (req_reg_off),
        .imm_off (req_imm_off),
        .use_imm (req_use_imm),
        .mode    (amode_e'(req_mode)),
        .size    (asize_e'(req_size)),
        .ea      (ea_c),
        .wb_value(wbv_c),
        .wants_wb(wants_wb_c)
    );

    agen_lane_ctl #(.BEAT_BYTES(BEAT_BYTES), .LANE_W(LANE_W)) u_lane (
        .ea_lo   (ea_c[LANE_W-1:0]),
        .size    (asize_e'(req_size)),
        .is_store(req_is_store),
        .wants_wb(wants_wb_c),
        .byte_en (be_c),
        .misalign(mis_c),
        .size_bad(szb_c),
        .wb_ok   (wbok_c)
    );

    agen_load_align #(.BEAT_W(BEAT_W), .LANE_W(LANE_W)) u_align (
        .beat  (ld_beat),
        .size  (asize_e'(ld_size)),
        .lo    (ld_addr_lo),
        .result(ld_c)
    );

    // Register address results on each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid    <= 1'b0;
            ea           <= '0;
            wb_value     <= '0;
            wb_en        <= 1'b0;
            byte_en      <= '0;
            misalign_err <= 1'b0;
            size_err     <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                ea           <= ea_c;
                wb_value     <= wbv_c;
                wb_en        <= wbok_c;
                byte_en      <= be_c;
                misalign_err <= mis_c;
                size_err     <= szb_c;
            end
        end
    end

    // Register the aligned load element on each returned beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid  <= 1'b0;
            ld_result <= '0;
        end else begin
            ld_valid <= ld_req;
            if (ld_req) ld_result <= ld_c;
        end
    end

    // R3
    post_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && ($past(req_mode) == 3'd5 || $past(req_mode) == 3'd6)
        |-> ea == $past(req_base));

    // R4
    no_wb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && ($past(req_mode) <= 3'd2 || $past(req_mode) == 3'd7)
        |-> !wb_en && wb_value == $past(req_base));

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (misalign_err || size_err) |-> !wb_en && byte_en == '0);

    // R5
    lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !misalign_err && !size_err
        |-> $countones(byte_en) == (32'd1 << $past(req_size)));

    // R7
    dbl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && $past(req_is_store) && $past(req_size) == 2'd3 |-> size_err);

    // R8
    byte_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && $past(ld_size) == 2'd0
        |-> ld_result[BEAT_W-1:32] == '0 && ld_result[31:8] == {24{ld_result[7]}});

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> $stable(ea) && !rsp_valid);
endmodule

// File: tb/tb_lsu_agen.sv
`timescale 1ns/1ps
module tb_lsu_agen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_is_store = 1'b0, req_use_imm = 1'b0;
    logic [31:0] req_base = '0, req_reg_off = '0;
    logic [4:0]  req_imm_off = '0;
    logic [2:0]  req_mode = '0;
    logic [1:0]  req_size = '0, ld_size = '0;
    logic        ld_req = 1'b0;
    logic [63:0] ld_beat = '0;
    logic [2:0]  ld_addr_lo = '0;
    logic        rsp_valid, wb_en, misalign_err, size_err, ld_valid;
    logic [31:0] ea, wb_value;
    logic [7:0]  byte_en;
    logic [63:0] ld_result;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    lsu_agen dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
        .req_base(req_base), .req_reg_off(req_reg_off), .req_imm_off(req_imm_off),
        .req_use_imm(req_use_imm), .req_mode(req_mode), .req_size(req_size),
        .ld_req(ld_req), .ld_beat(ld_beat), .ld_size(ld_size), .ld_addr_lo(ld_addr_lo),
        .rsp_valid(rsp_valid), .ea(ea), .wb_value(wb_value), .wb_en(wb_en),
        .byte_en(byte_en), .misalign_err(misalign_err), .size_err(size_err),
        .ld_valid(ld_valid), .ld_result(ld_result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_load(input logic [63:0] beat, input logic [1:0] sz,
                                             input logic [2:0] lo);
        logic [7:0]  b;
        logic [15:0] h;
        logic [31:0] w;
        b = beat[8*lo +: 8];
        h = beat[32*lo[2] + 16*lo[1] +: 16];
        w = beat[32*lo[2] +: 32];
        case (sz)
            2'd0: return {32'd0, {24{b[7]}}, b};
            2'd1: return {32'd0, {16{h[15]}}, h};
            2'd2: return {32'd0, w};
            default: return beat;
        endcase
    endfunction

    logic [31:0] bases[4] = '{32'h0000_1000, 32'h8000_0003, 32'hFFFF_FFF8, 32'h0000_0006};

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int cnt = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ea", {32'd0, ea}, 64'd0);
        check("R1 flags", {58'd0, rsp_valid, wb_en, misalign_err, size_err, ld_valid, |byte_en}, 64'd0);
        check("R1 ld_result", ld_result, 64'd0);
        rst_n = 1'b1;

        for (int m = 0; m < 8; m++)
        for (int s = 0; s < 4; s++)
        for (int st = 0; st < 2; st++)
        for (int bi = 0; bi < 4; bi++)
        for (int oi = 0; oi < 5; oi++) begin
            logic [31:0] off, scaled, modv, e_ea, e_wbv;
            logic        e_mis, e_serr, e_wb;
            logic [7:0]  e_be;
            logic [1:0]  lsz;
            logic [2:0]  llo;
            logic [63:0] lbeat;
            @(negedge clk);
            req_valid    = 1'b1;
            req_mode     = 3'(m);
            req_size     = 2'(s);
            req_is_store = st[0];
            req_base     = bases[bi];
            req_use_imm  = (oi < 3);
            req_imm_off  = (oi == 0) ? 5'd0 : (oi == 1) ? 5'd1 : 5'd31;
            req_reg_off  = (oi == 3) ? 32'd3 : 32'h4000_0001;
            off          = (oi < 3) ? {27'd0, req_imm_off} : req_reg_off;
            // Same-cycle load beat alignment
            lsz   = 2'(cnt >> 3);
            llo   = 3'(cnt);
            lbeat = {2{32'h9A7B_5C3D}} ^ (64'(cnt) * 64'h0101_0101_0101_0101);
            ld_req = 1'b1; ld_size = lsz; ld_addr_lo = llo; ld_beat = lbeat;
            cnt++;

            // R2: offset scaled by element size
            scaled = off << s;
            modv   = (m == 2 || m == 4 || m == 6) ? req_base - scaled : req_base + scaled;
            e_ea   = (m >= 1 && m <= 4) ? modv : req_base;
            e_wbv  = (m >= 3 && m <= 6) ? modv : req_base;
            e_mis  = (e_ea & ((32'd1 << s) - 32'd1)) != 0;
            e_serr = (st == 1) && (s == 3);
            e_wb   = (m >= 3 && m <= 6) && !e_mis && !e_serr;
            e_be   = (e_mis || e_serr) ? 8'd0 : 8'(((16'd1 << (1 << s)) - 16'd1) << e_ea[2:0]);

            @(negedge clk);
            // R10: one-cycle latency
            check("R10 rsp_valid", {63'd0, rsp_valid}, 64'd1);
            check("R3 R2 ea", {32'd0, ea}, {32'd0, e_ea});
            check("R4 wb_value", {32'd0, wb_value}, {32'd0, e_wbv});
            check("R4 R6 R7 wb_en", {63'd0, wb_en}, {63'd0, e_wb});
            check("R5 byte_en", {56'd0, byte_en}, {56'd0, e_be});
            check("R6 misalign_err", {63'd0, misalign_err}, {63'd0, e_mis});
            check("R7 size_err", {63'd0, size_err}, {63'd0, e_serr});
            check("R10 ld_valid", {63'd0, ld_valid}, 64'd1);
            check((lsz < 2) ? "R8 ld_result" : "R9 ld_result", ld_result, exp_load(lbeat, lsz, llo));
            req_valid = 1'b0;
            ld_req    = 1'b0;
        end

        // R10: outputs hold with no request while inputs change
        begin
            logic [31:0] ea_prev;
            logic [63:0] ld_prev;
            @(negedge clk);
            ea_prev = ea; ld_prev = ld_result;
            req_base = 32'h1234_5678; req_mode = 3'd3; ld_beat = ~ld_beat;
            repeat (2) @(negedge clk);
            check("R10 ea hold", {32'd0, ea}, {32'd0, ea_prev});
            check("R10 ld hold", ld_result, ld_prev);
            check("R10 rsp_valid low", {62'd0, rsp_valid, ld_valid}, 64'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule